// File: doc/BRIEF.md
# Timebase Interval Timer with Interrupt Request

This block is a free-running binary up-counter that advances on every cycle in which an internal count enable is high. Software picks one of four counter bits as the interval tap. Each time that bit carries out, which is its 1-to-0 transition caused by an increment, a sticky overflow flag is raised. The result is a programmable periodic tick whose period is a power of two.

A small register port lets software select the tap, set an interrupt enable, read and clear the flag, and zero the counter. Writes use a single-cycle strobe, and read data is combinational. The interrupt request is simply the flag gated by the enable. Interrupt software is expected to clear the flag by writing zero to it, and to do so while the enable is off.

Top module: `tbt_interval`

## Requirements
- R1: On each clock with `cnt_en` high and no counter-clear write, the counter advances by one and wraps modulo 2^CNT_W. With `cnt_en` low it holds its value.
- R2: When an increment carries out of the selected tap bit (the bit goes from 1 to 0), the flag reads 1 after that clock. This happens whatever the enable value is.
- R3: `irq` is 1 exactly when both the flag and the enable read 1.
- R4: Once set, the flag stays set until a write with `wr_data[1]` = 0. Neither reading it nor an asserted `irq` clears it.
- R5: A write that sets the enable while the flag is already 1 raises `irq` on the next cycle, without any new carry.
- R6: Writing 1 to `wr_data[1]` never sets the flag. If a carry and a flag-clearing write fall in the same clock, the flag ends up set.
- R7: `wr_data[3:2]` (read back on `rd_data[3:2]`) selects tap bit CNT_W-7+2*sel, which is bits 11, 13, 15 and 17 for the default CNT_W=18. The period is 2^(tap+1) counted cycles.
- R8: A write with `wr_data[4]` = 1 sets the counter to zero on that clock. No carry is counted in that clock, the flag is left unchanged, and `rd_data[4]` always reads 0.
- R9: A clock with `rst` high clears the counter, flag and enable, and selects tap 0. Afterwards `rd_data` reads 0 and `irq` is 0.
- R10: Register layout: bit 0 holds the enable, bit 1 the flag, bits 3:2 the tap select, and bit 4 the counter clear. Every write loads the enable and the select from the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Internal count enable |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_data | input | 5 | Write data: clear[4], select[3:2], flag[1], enable[0] |
| rd_data | output | 5 | Combinational register read data |
| irq | output | 1 | Interrupt request, flag AND enable |

## Verification
Two pairs of events can land in the same clock. The first is a tap carry together with a write that clears the flag. The second is a tap carry together with a counter-clear write. The bench tracks its own copy of the counter and waits until the low tap bits are all ones before it issues the write, so that both events fall on one edge. It then expects the flag to be set in the first case and left untouched in the second. Every cycle is compared against a reference built from the requirements, so the exact cycle of each flag change is judged, not just its eventual value.

// File: rtl/tbt_interval.sv
module tbt_interval #(
  parameter int CNT_W = 18
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cnt_en,
  input  logic       wr_en,
  input  logic [4:0] wr_data,
  output logic [4:0] rd_data,
  output logic       irq
);
  localparam int TAP_LO = CNT_W - 7;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] tap_mask;
  logic             flag;
  logic             ien;
  logic [1:0]       sel;

  always_comb begin
    tap_mask = '0;
    for (int i = 0; i < CNT_W; i++)
      if (i <= TAP_LO + 2 * int'(sel)) tap_mask[i] = 1'b1;
  end

  wire cnt_clr  = wr_en & wr_data[4];
  wire carry    = cnt_en & ~cnt_clr & ((cnt & tap_mask) == tap_mask);
  wire flag_clr = wr_en & ~wr_data[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      flag <= 1'b0;
      ien  <= 1'b0;
      sel  <= 2'd0;
    end else begin
      if (cnt_clr)     cnt <= '0;
      else if (cnt_en) cnt <= cnt + 1'b1;
      flag <= carry | (flag & ~flag_clr);
      if (wr_en) begin
        ien <= wr_data[0];
        sel <= wr_data[3:2];
      end
    end
  end

  assign rd_data = {1'b0, sel, flag, ien};
  assign irq     = flag & ien;
endmodule

// File: rtl/tbt_interval_chk.sv
module tbt_interval_chk #(
  parameter int CNT_W = 18
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_any,
  input logic             wr_cnt_clr,
  input logic [4:0]       rd_data,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic [1:0]       sel
);
  localparam int TAP_LO = CNT_W - 7;
  logic tap_bit;
  assign tap_bit = cnt[TAP_LO + 2 * int'(sel)];

  AST_REQ_GATE: assert property (@(posedge clk) disable iff (rst) irq == (rd_data[1] & rd_data[0])); // R3
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst) ($past(rd_data[1]) && !$past(wr_any)) |-> rd_data[1]); // R4
  AST_SET_ON_CARRY: assert property (@(posedge clk) disable iff (rst) (!$past(wr_any) && $past(tap_bit) && !tap_bit) |-> rd_data[1]); // R2
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst) $past(wr_cnt_clr) |-> (cnt == '0)); // R8
  AST_CLR_READS0: assert property (@(posedge clk) disable iff (rst) rd_data[4] == 1'b0); // R8
  AST_RESET_STATE: assert property (@(posedge clk) $past(rst) |-> (rd_data == 5'd0 && !irq)); // R9
endmodule

bind tbt_interval tbt_interval_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .wr_any(wr_en), .wr_cnt_clr(wr_en & wr_data[4]),
  .rd_data(rd_data), .irq(irq), .cnt(cnt), .sel(sel)
);

// File: tb/tbt_interval_tb_top.sv
`timescale 1ns/100ps
module tbt_interval_tb_top;
  localparam int CW = 10;
  localparam int TL = CW - 7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_data = 5'd0;
  logic [4:0] rd_data;
  logic       irq;

  always #2.5 clk = ~clk;

  tbt_interval #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  typedef struct {
    logic [4:0] rd;
    logic       rq;
    string      tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [CW-1:0] m_cnt = '0;
  logic          m_flag = 1'b0;
  logic          m_ien = 1'b0;
  logic [1:0]    m_sel = 2'd0;

  function automatic bit low_ones();
    for (int b = 0; b <= TL + 2 * int'(m_sel); b++)
      if (!m_cnt[b]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic cyc(input logic r, input logic en, input logic w,
                     input logic [4:0] d, input string tag);
    exp_t e;
    bit clr, ev;
    @(negedge clk);
    rst = r; cnt_en = en; wr_en = w; wr_data = d;
    if (r) begin
      m_cnt = '0; m_flag = 1'b0; m_ien = 1'b0; m_sel = 2'd0;
    end else begin
      clr = w && d[4];
      ev  = en && !clr && low_ones();
      m_flag = ev | (m_flag & !(w && !d[1]));
      if (clr) m_cnt = '0;
      else if (en) m_cnt = m_cnt + 1'b1;
      if (w) begin
        m_ien = d[0];
        m_sel = d[3:2];
      end
    end
    e.rd = {1'b0, m_sel, m_flag, m_ien};
    e.rq = m_flag & m_ien;
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        total++;
        if (rd_data !== e.rd || irq !== e.rq) begin
          bad++;
          $display("FAIL %s: actual rd=%b irq=%b expected rd=%b irq=%b",
                   e.tag, rd_data, irq, e.rd, e.rq);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc(1, 0, 0, 5'b00000, "R9");
    repeat (40) cyc(0, 1, 0, 5'b00000, "R2");
    repeat (10) cyc(0, 0, 0, 5'b00000, "R4");
    cyc(0, 0, 1, 5'b00011, "R5");
    repeat (5) cyc(0, 0, 0, 5'b00000, "R3");
    cyc(0, 0, 1, 5'b00001, "R4");
    cyc(0, 0, 1, 5'b00011, "R6");
    repeat (3) cyc(0, 0, 0, 5'b00000, "R6");
    while (!low_ones()) cyc(0, 1, 0, 5'b00000, "R1");
    cyc(0, 1, 1, 5'b00001, "R6");
    repeat (4) cyc(0, 1, 0, 5'b00000, "R6");
    for (int s = 1; s < 4; s++) begin
      cyc(0, 1, 1, {1'b1, 2'(s), 2'b00}, "R8");
      repeat ((1 << (TL + 2 * s + 1)) + 6) cyc(0, 1, 0, 5'b00000, "R7");
    end
    cyc(0, 1, 1, {1'b1, 2'd3, 2'b10}, "R8");
    repeat (4) cyc(0, 1, 0, 5'b00000, "R8");
    cyc(0, 1, 1, 5'b00000, "R10");
    while (!low_ones()) cyc(0, 1, 0, 5'b00000, "R1");
    cyc(0, 1, 1, 5'b10010, "R8");
    repeat (4) cyc(0, 1, 0, 5'b00000, "R8");
    for (int i = 0; i < 200; i++) cyc(0, (i % 3) != 0, 0, 5'b00000, "R1");
    cyc(0, 0, 1, 5'b01001, "R10");
    repeat (1100) cyc(0, 1, 0, 5'b00000, "R7");
    repeat (2) cyc(1, 0, 0, 5'b00000, "R9");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule